// File: doc/BRIEF.md
# Calendar Clock Core with Staged Commit

This block keeps a real-time calendar: seconds, minutes, hours, day of month, weekday, month and a 7-bit year. The year field counts from 1968, and the month field counts from 1. A one-second tick input advances the calendar. The tick rolls over into the next field at 60 seconds, 60 minutes and 24 hours, and at the end of each month. Month lengths follow the calendar, and every year offset divisible by four is a leap year. An alarm comparator checks the calendar value produced on each tick against a stored alarm value. It raises an interrupt on a match, and it can disarm itself after one hit.

The host uses a 16-bit register bus with an address, a write enable, a read strobe, write data and combinational read data. Host writes to the calendar or alarm fields go into shadow storage. A write of 1 to the trigger register copies every field written since the last commit into the live registers, all in one step. Copying the whole set at once keeps a half-written time from being visible to the tick logic or the alarm compare. The commit takes a fixed number of clock cycles, and a busy bit can be polled for the whole of that time.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset the calendar reads 00:00:00, day of month 1, month 1, weekday 1, year offset 0; busy (bit 6 of offset 0x00) reads 0 and irqOut is 0.
- R2: Calendar fields are at offsets 0x0A..0x16 and alarm fields at 0x18..0x24, stride 2, index order seconds, minutes, hours, day of month, weekday, month, year. A write to a field does not change what that field reads back until the host writes 1 to offset 0x3C. The written values are readable once the commit ends.
- R3: After a trigger write, busy reads 1 for exactly 4 cycles and then 0. Trigger writes made while busy is 1 are ignored.
- R4: A tick that arrives while busy is 1 is dropped, so the committed value is not advanced.
- R5: Each tick adds one second. At 59 the seconds wrap to 0 and carry into minutes, minutes wrap at 59 into hours, and hours wrap at 23 into the day.
- R6: The day of month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, and 31 for the other months except February. February has 29 days when the year offset is divisible by 4 and 28 days otherwise.
- R7: On each day change the weekday counts up from 1 to 7 and then back to 1. When the day wraps in month 12, the month becomes 1 and the year increments. Year offset 127 wraps to 0.
- R8: When the alarm enable (bit 0 of offset 0x04) is 1 and the calendar value after a tick equals the alarm fields, status bit 0 at 0x02 becomes 1 and irqOut goes high. With the enable at 0, no hit is recorded.
- R9: When bit 4 of offset 0x08 is 1, the weekday is left out of the alarm compare. When that bit is 0, a weekday mismatch prevents a hit.
- R10: When one-shot mode (bit 2 of 0x04) is set, a hit clears the alarm enable bit. Without one-shot mode, the enable stays set after a hit.
- R11: A read of offset 0x02 (busRe high) returns the status and then clears it, which deasserts irqOut.
- R12: Every hit sets bit 4 of offset 0x2E. The host clears that bit by writing 0 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| busAddr | input | 6 | Register byte address |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (used for read-to-clear) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| irqOut | output | 1 | Alarm interrupt, high while status bit is set |

## Verification
The hardest cases to reach from the ports are the carry chains that run through several fields at once: the last second of a year, a 29th or 28th of February, and the weekday wrapping on the same tick. Random starting times are loaded through the commit path. Half of them are forced to the last second of the last day of a random month and year, and each is then advanced one to three ticks against a bench calendar model. A tick that lands inside the commit window is another rare case. It is produced on purpose by pulsing the tick right after a trigger write. A second trigger is also written while busy is high, to show that the commit window does not restart.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 16;
  localparam int NUM_FIELDS = 7;
  localparam int YEAR_W     = 7;
  localparam int IDX_W      = $clog2(NUM_FIELDS);

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 6'h02;
  localparam logic [ADDR_W-1:0] ADR_IRQEN  = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 6'h08;
  localparam logic [ADDR_W-1:0] ADR_TIME0  = 6'h0A;
  localparam logic [ADDR_W-1:0] ADR_ALARM0 = 6'h18;
  localparam logic [ADDR_W-1:0] ADR_PEND   = 6'h2E;
  localparam logic [ADDR_W-1:0] ADR_TRIG   = 6'h3C;

  localparam int BUSY_BIT    = 6;
  localparam int HIT_BIT     = 0;
  localparam int EN_BIT      = 0;
  localparam int ONESHOT_BIT = 2;
  localparam int DOWMASK_BIT = 4;
  localparam int PEND_BIT    = 4;

  typedef struct packed {
    logic [YEAR_W-1:0] yr;
    logic [3:0]        mon;
    logic [2:0]        dow;
    logic [4:0]        dom;
    logic [4:0]        hr;
    logic [5:0]        min;
    logic [5:0]        sec;
  } calTime_t;

  typedef struct packed {
    logic             wrTime;
    logic             wrAlarm;
    logic [IDX_W-1:0] fieldIdx;
    logic             wrIrqEn;
    logic             wrMask;
    logic             wrPending;
    logic             rdStatus;
    logic             tickTaken;
    logic             commitApply;
  } ctrlStrobe_t;

  localparam calTime_t RESET_TIME = '{yr: '0, mon: 4'd1, dow: 3'd1, dom: 5'd1,
                                      hr: '0, min: '0, sec: '0};

  function automatic logic inBank(input logic [ADDR_W-1:0] addr,
                                  input logic [ADDR_W-1:0] base);
    return (addr >= base) && ({1'b0, addr} < ({1'b0, base} + (ADDR_W+1)'(2*NUM_FIELDS)))
           && !addr[0];
  endfunction

  function automatic logic [IDX_W-1:0] bankIdx(input logic [ADDR_W-1:0] addr,
                                               input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] diff;
    diff = addr - base;
    return diff[IDX_W:1];
  endfunction

  function automatic logic [DATA_W-1:0] getField(input calTime_t t, input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return DATA_W'(t.sec);
      3'd1:    return DATA_W'(t.min);
      3'd2:    return DATA_W'(t.hr);
      3'd3:    return DATA_W'(t.dom);
      3'd4:    return DATA_W'(t.dow);
      3'd5:    return DATA_W'(t.mon);
      default: return DATA_W'(t.yr);
    endcase
  endfunction

  function automatic calTime_t setField(input calTime_t t, input logic [IDX_W-1:0] idx,
                                        input logic [DATA_W-1:0] v);
    calTime_t n;
    n = t;
    case (idx)
      3'd0:    n.sec = v[5:0];
      3'd1:    n.min = v[5:0];
      3'd2:    n.hr  = v[4:0];
      3'd3:    n.dom = v[4:0];
      3'd4:    n.dow = v[2:0];
      3'd5:    n.mon = v[3:0];
      default: n.yr  = v[YEAR_W-1:0];
    endcase
    return n;
  endfunction

  function automatic logic [4:0] daysInMonth(input logic [3:0] mon, input logic [YEAR_W-1:0] yr);
    case (mon)
      4'd2:                     return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

  function automatic calTime_t advance(input calTime_t t);
    calTime_t n;
    n = t;
    if (t.sec != 6'd59) n.sec = 6'(t.sec + 6'd1);
    else begin
      n.sec = '0;
      if (t.min != 6'd59) n.min = 6'(t.min + 6'd1);
      else begin
        n.min = '0;
        if (t.hr != 5'd23) n.hr = 5'(t.hr + 5'd1);
        else begin
          n.hr  = '0;
          n.dow = (t.dow >= 3'd7) ? 3'd1 : 3'(t.dow + 3'd1);
          if (t.dom < daysInMonth(t.mon, t.yr)) n.dom = 5'(t.dom + 5'd1);
          else begin
            n.dom = 5'd1;
            if (t.mon < 4'd12) n.mon = 4'(t.mon + 4'd1);
            else begin
              n.mon = 4'd1;
              n.yr  = YEAR_W'(t.yr + 1'b1);
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic alarmMatch(input calTime_t t, input calTime_t a, input logic skipDow);
    return (t.sec == a.sec) && (t.min == a.min) && (t.hr == a.hr) && (t.dom == a.dom) &&
           (t.mon == a.mon) && (t.yr == a.yr) && (skipDow || (t.dow == a.dow));
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl import rtc_cal_pkg::*; #(
  parameter int COMMIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              trigBit,
  output ctrlStrobe_t       strobes,
  output logic              busy
);
  localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             trigWr;
  logic             timeHit;
  logic             alarmHit;

  assign trigWr   = busWe && (busAddr == ADR_TRIG) && trigBit;
  assign timeHit  = inBank(busAddr, ADR_TIME0);
  assign alarmHit = inBank(busAddr, ADR_ALARM0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (!busyQ) begin
      if (trigWr) begin
        busyQ <= 1'b1;
        cntQ  <= CNT_W'(COMMIT_CYCLES - 1);
      end
    end else if (cntQ == '0) begin
      busyQ <= 1'b0;
    end else begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.wrTime      = busWe && timeHit;
    strobes.wrAlarm     = busWe && alarmHit;
    strobes.fieldIdx    = timeHit ? bankIdx(busAddr, ADR_TIME0) : bankIdx(busAddr, ADR_ALARM0);
    strobes.wrIrqEn     = busWe && (busAddr == ADR_IRQEN);
    strobes.wrMask      = busWe && (busAddr == ADR_MASK);
    strobes.wrPending   = busWe && (busAddr == ADR_PEND);
    strobes.rdStatus    = busRe && (busAddr == ADR_STATUS);
    strobes.tickTaken   = secTick && !busyQ;
    strobes.commitApply = busyQ && (cntQ == '0);
  end

  assign busy = busyQ;

  // R3: a commit window only opens on a trigger write
  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyQ) |-> $past(trigWr));

  // R3: the window closes only through the apply step
  assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busyQ) |-> $past(strobes.commitApply));
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath import rtc_cal_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobes,
  input  logic              busy,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  calTime_t shadowTime, shadowAlarm, liveTime, liveAlarm;
  calTime_t mergedTime, mergedAlarm, nextTime;
  logic [NUM_FIELDS-1:0] dirtyTime, dirtyAlarm, wrTimeVec, wrAlarmVec;
  logic alarmEnQ, oneShotQ, dowMaskQ, statusQ, pendingQ;
  logic fireNow;

  // Fold dirty shadow fields into the live value for the commit
  always_comb begin
    mergedTime  = liveTime;
    mergedAlarm = liveAlarm;
    wrTimeVec   = '0;
    wrAlarmVec  = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (dirtyTime[i])
        mergedTime = setField(mergedTime, IDX_W'(i), getField(shadowTime, IDX_W'(i)));
      if (dirtyAlarm[i])
        mergedAlarm = setField(mergedAlarm, IDX_W'(i), getField(shadowAlarm, IDX_W'(i)));
      wrTimeVec[i]  = strobes.wrTime  && (strobes.fieldIdx == IDX_W'(i));
      wrAlarmVec[i] = strobes.wrAlarm && (strobes.fieldIdx == IDX_W'(i));
    end
  end

  assign nextTime = advance(liveTime);
  assign fireNow  = strobes.tickTaken && alarmEnQ && alarmMatch(nextTime, liveAlarm, dowMaskQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowTime  <= RESET_TIME;
      shadowAlarm <= RESET_TIME;
      dirtyTime   <= '0;
      dirtyAlarm  <= '0;
    end else begin
      if (strobes.wrTime)  shadowTime  <= setField(shadowTime,  strobes.fieldIdx, busWdata);
      if (strobes.wrAlarm) shadowAlarm <= setField(shadowAlarm, strobes.fieldIdx, busWdata);
      dirtyTime  <= (strobes.commitApply ? '0 : dirtyTime)  | wrTimeVec;
      dirtyAlarm <= (strobes.commitApply ? '0 : dirtyAlarm) | wrAlarmVec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      liveTime  <= RESET_TIME;
      liveAlarm <= RESET_TIME;
    end else if (strobes.commitApply) begin
      liveTime  <= mergedTime;
      liveAlarm <= mergedAlarm;
    end else if (strobes.tickTaken) begin
      liveTime  <= nextTime;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarmEnQ <= 1'b0;
      oneShotQ <= 1'b0;
      dowMaskQ <= 1'b0;
      statusQ  <= 1'b0;
      pendingQ <= 1'b0;
    end else begin
      if (strobes.wrIrqEn) begin
        alarmEnQ <= busWdata[EN_BIT];
        oneShotQ <= busWdata[ONESHOT_BIT];
      end
      if (fireNow && oneShotQ) alarmEnQ <= 1'b0;
      if (strobes.wrMask) dowMaskQ <= busWdata[DOWMASK_BIT];
      if (fireNow) statusQ <= 1'b1;
      else if (strobes.rdStatus) statusQ <= 1'b0;
      if (fireNow) pendingQ <= 1'b1;
      else if (strobes.wrPending) pendingQ <= busWdata[PEND_BIT];
    end
  end

  always_comb begin
    busRdata = '0;
    if (inBank(busAddr, ADR_TIME0))
      busRdata = getField(liveTime, bankIdx(busAddr, ADR_TIME0));
    else if (inBank(busAddr, ADR_ALARM0))
      busRdata = getField(liveAlarm, bankIdx(busAddr, ADR_ALARM0));
    else begin
      case (busAddr)
        ADR_CTRL:   busRdata[BUSY_BIT] = busy;
        ADR_STATUS: busRdata[HIT_BIT]  = statusQ;
        ADR_IRQEN: begin
          busRdata[EN_BIT]      = alarmEnQ;
          busRdata[ONESHOT_BIT] = oneShotQ;
        end
        ADR_MASK:   busRdata[DOWMASK_BIT] = dowMaskQ;
        ADR_PEND:   busRdata[PEND_BIT]    = pendingQ;
        default:    busRdata = '0;
      endcase
    end
  end

  assign irqOut = statusQ;

  // R4: during a commit the calendar moves only on the apply step
  assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && !$past(strobes.commitApply) |-> $stable(liveTime));

  // R5: seconds wrap on an accepted tick
  assert_sec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.tickTaken && (liveTime.sec == 6'd59) |=> (liveTime.sec == 6'd0));

  // R8: a new hit requires the enable
  assert_hit_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusQ) |-> $past(alarmEnQ));

  // R10: one-shot hit disarms the alarm
  assert_oneshot_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusQ) && $past(oneShotQ) |-> !alarmEnQ);

  // R11: a status read clears the status unless a hit coincides
  assert_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rdStatus && !fireNow |=> !statusQ);

  // R12: every hit marks the pending flag
  assert_pending_mark_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusQ) |-> pendingQ);
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top import rtc_cal_pkg::*; #(
  parameter int COMMIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  ctrlStrobe_t strobes;
  logic        busy;

  rtc_cal_ctrl #(.COMMIT_CYCLES(COMMIT_CYCLES)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .secTick (secTick),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .trigBit (busWdata[0]),
    .strobes (strobes),
    .busy    (busy)
  );

  rtc_cal_datapath dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .busy     (busy),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/rtc_calendar_top_tb_top.sv
module rtc_calendar_top_tb_top;
  typedef logic [6:0][15:0] tvec_t;  // [0]sec [1]min [2]hr [3]dom [4]dow [5]mon [6]yr

  logic        clk = 1'b0, rst_n = 1'b0, secTick = 1'b0, busWe = 1'b0, busRe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  wire  [15:0] busRdata;
  wire         irqOut;
  int checks = 0, fails = 0;
  bit done = 0;

  rtc_calendar_top dut_i (.clk(clk), .rst_n(rst_n), .secTick(secTick), .busAddr(busAddr),
    .busWe(busWe), .busRe(busRe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge, consuming one rising edge
  task automatic busWrite(input logic [5:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [15:0] d);
    busAddr = a; busRe = 1'b1; #1 d = busRdata;
    @(negedge clk); busRe = 1'b0;
  endtask

  task automatic tickOnce();
    secTick = 1'b1; @(negedge clk); secTick = 1'b0;
  endtask

  task automatic waitIdle();
    logic [15:0] d;
    for (int n = 0; n < 20; n++) begin
      busRead(6'h00, d);
      if (!d[6]) return;
    end
    check("R3 busy stuck", 32'(d[6]), 0);
  endtask

  task automatic loadFields(input logic [5:0] base, input tvec_t t);
    for (int i = 0; i < 7; i++) busWrite(6'(base + 2*i), t[i]);
  endtask

  task automatic commit();
    busWrite(6'h3C, 16'h1); waitIdle();
  endtask

  task automatic readFields(input logic [5:0] base, output tvec_t t);
    for (int i = 0; i < 7; i++) begin
      logic [15:0] d;
      busRead(6'(base + 2*i), d);
      t[i] = d;
    end
  endtask

  task automatic checkFields(input string req, input tvec_t act, input tvec_t exp);
    for (int i = 0; i < 7; i++) check($sformatf("%s field %0d", req, i), 32'(act[i]), 32'(exp[i]));
  endtask

  function automatic int tbDim(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic tvec_t tbAdvance(input tvec_t t);
    tvec_t n = t;
    n[0] = t[0] + 1;
    if (n[0] == 60) begin
      n[0] = 0; n[1] = t[1] + 1;
      if (n[1] == 60) begin
        n[1] = 0; n[2] = t[2] + 1;
        if (n[2] == 24) begin
          n[2] = 0;
          n[4] = (t[4] == 7) ? 16'd1 : 16'(t[4] + 1);
          n[3] = t[3] + 1;
          if (int'(n[3]) > tbDim(int'(t[5]), int'(t[6]))) begin
            n[3] = 1; n[5] = t[5] + 1;
            if (n[5] == 13) begin n[5] = 1; n[6] = 16'((t[6] + 1) % 128); end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic tvec_t mk(input int yr, input int mon, input int dom, input int dow,
                               input int hr, input int mi, input int s);
    tvec_t t;
    t[0] = 16'(s); t[1] = 16'(mi); t[2] = 16'(hr); t[3] = 16'(dom);
    t[4] = 16'(dow); t[5] = 16'(mon); t[6] = 16'(yr);
    return t;
  endfunction

  task automatic tickCheck(input string req, input tvec_t start);
    tvec_t got;
    loadFields(6'h0A, start); commit();
    tickOnce();
    readFields(6'h0A, got);
    checkFields(req, got, tbAdvance(start));
  endtask

  initial begin
    tvec_t t, got, al;
    logic [15:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    readFields(6'h0A, got);
    checkFields("R1 reset calendar", got, mk(0, 1, 1, 1, 0, 0, 0));
    busRead(6'h00, d); check("R1 busy after reset", 32'(d), 0);
    check("R1 irqOut after reset", 32'(irqOut), 0);

    // R2 staged writes invisible before trigger
    busWrite(6'h0A, 16'd33);
    busWrite(6'h18, 16'd7);
    busRead(6'h0A, d); check("R2 time staged", 32'(d), 0);
    busRead(6'h18, d); check("R2 alarm staged", 32'(d), 0);
    commit();
    busRead(6'h0A, d); check("R2 time committed", 32'(d), 33);
    busRead(6'h18, d); check("R2 alarm committed", 32'(d), 7);

    // R3 busy window length, second trigger ignored
    busWrite(6'h3C, 16'h1);
    busRead(6'h00, d); check("R3 busy cycle1", 32'(d[6]), 1);
    busWrite(6'h3C, 16'h1);
    busRead(6'h00, d); check("R3 busy cycle3", 32'(d[6]), 1);
    busRead(6'h00, d); check("R3 busy cycle4", 32'(d[6]), 1);
    busRead(6'h00, d); check("R3 busy released", 32'(d[6]), 0);

    // R4 tick during commit dropped
    busWrite(6'h0A, 16'd10);
    busWrite(6'h3C, 16'h1);
    tickOnce();
    waitIdle();
    busRead(6'h0A, d); check("R4 committed value wins", 32'(d), 10);
    tickOnce();
    busRead(6'h0A, d); check("R5 tick after commit", 32'(d), 11);

    // R5 R6 R7 directed rollovers
    tickCheck("R5 hour carry", mk(5, 6, 14, 2, 13, 59, 59));
    tickCheck("R6 leap feb 28", mk(0, 2, 28, 4, 23, 59, 59));
    tickCheck("R6 leap feb 29", mk(4, 2, 29, 4, 23, 59, 59));
    tickCheck("R6 plain feb 28", mk(1, 2, 28, 4, 23, 59, 59));
    tickCheck("R6 april 30", mk(9, 4, 30, 6, 23, 59, 59));
    tickCheck("R7 year wrap and dow 7", mk(127, 12, 31, 7, 23, 59, 59));

    // R5 R6 R7 random calendars against the bench model
    for (int it = 0; it < 30; it++) begin
      int yr = $urandom % 128, mon = 1 + $urandom % 12;
      int dim = tbDim(mon, yr);
      int nt = 1 + $urandom % 3;
      tvec_t e;
      if ($urandom % 2) t = mk(yr, mon, dim, 1 + $urandom % 7, 23, 59, 59 - $urandom % 2);
      else t = mk(yr, mon, 1 + $urandom % dim, 1 + $urandom % 7, $urandom % 24,
                  $urandom % 60, $urandom % 60);
      loadFields(6'h0A, t); commit();
      readFields(6'h0A, got); checkFields("R2 random load", got, t);
      e = t;
      for (int k = 0; k < nt; k++) begin tickOnce(); e = tbAdvance(e); end
      readFields(6'h0A, got); checkFields("R5 R6 R7 random advance", got, e);
    end

    // R8 R11 R12 alarm hit
    t  = mk(10, 3, 4, 3, 10, 0, 5);
    al = mk(10, 3, 4, 3, 10, 0, 6);
    busWrite(6'h04, 16'h0001);
    loadFields(6'h0A, t); loadFields(6'h18, al); commit();
    readFields(6'h18, got); checkFields("R2 alarm readback", got, al);
    tickOnce();
    check("R8 irq on match", 32'(irqOut), 1);
    busRead(6'h02, d); check("R8 status hit", 32'(d), 1);
    check("R11 irq cleared by read", 32'(irqOut), 0);
    busRead(6'h02, d); check("R11 status cleared", 32'(d), 0);
    busRead(6'h2E, d); check("R12 pending set", 32'(d), 16'h0010);
    busWrite(6'h2E, 16'h0000);
    busRead(6'h2E, d); check("R12 pending cleared", 32'(d), 0);
    busRead(6'h04, d); check("R10 enable kept without one-shot", 32'(d), 1);
    tickOnce();
    check("R8 no hit off match", 32'(irqOut), 0);

    // R8 disabled alarm
    busWrite(6'h04, 16'h0000);
    loadFields(6'h0A, t); commit();
    tickOnce();
    check("R8 disabled no irq", 32'(irqOut), 0);
    busRead(6'h02, d); check("R8 disabled no status", 32'(d), 0);

    // R9 weekday mask
    al[4] = 16'd5;
    busWrite(6'h04, 16'h0001);
    loadFields(6'h0A, t); loadFields(6'h18, al); commit();
    tickOnce();
    check("R9 dow mismatch unmasked", 32'(irqOut), 0);
    busWrite(6'h08, 16'h0010);
    loadFields(6'h0A, t); commit();
    tickOnce();
    check("R9 dow masked hit", 32'(irqOut), 1);
    busRead(6'h02, d);

    // R10 one-shot
    busWrite(6'h04, 16'h0005);
    loadFields(6'h0A, t); commit();
    tickOnce();
    check("R10 one-shot hit", 32'(irqOut), 1);
    busRead(6'h04, d); check("R10 enable self-cleared", 32'(d), 16'h0004);
    busRead(6'h02, d);
    loadFields(6'h0A, t); commit();
    tickOnce();
    check("R10 no second hit", 32'(irqOut), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule